// File: doc/BRIEF.md
# Paired Alarm Status Registers

This block gathers a vector of alarm inputs, arranged in byte-wide groups, and presents each group to a microprocessor read port in two ways. The first view is live: it shows the alarm inputs exactly as they stand in the cycle of the read. The second view is sticky: each bit records that its alarm has been active since the last time software read that view. Software polls the sticky view to learn about short alarms it would otherwise miss. It reads the live view to see which conditions still hold.

Each group occupies two neighbouring addresses. The live view sits at an even address and the sticky view at the next odd one. Reading a sticky view returns the bits as they stood before the read and then clears them. An alarm that is still active in the read cycle sets its bit again at once, so no event is lost between the read and the clear. A small read-cycle state machine (`ST_IDLE`, `ST_LIVE`, `ST_STICKY`, `ST_VOID`) records what kind of access the previous cycle made. It drives the read data for exactly one cycle after each strobe. A summary flag reports whether any sticky bit is set.

State transitions happen on every clock. Without a strobe the machine goes to `ST_IDLE`. A strobe at a live address goes to `ST_LIVE`, a strobe at a sticky address goes to `ST_STICKY`, and a strobe anywhere else goes to `ST_VOID`. This holds from any state.

Top module: `asr_alarm_regs`

## Requirements
- R1: A strobe at live address BASE+2g returns alarm group g, which is input bits [8g+7:8g], as sampled at the strobe edge. The value appears on rd_data in the cycle after the strobe.
- R2: A read of a live address leaves every sticky bit unchanged, apart from setting bits for alarms that are active.
- R3: A sticky bit sets at the first clock edge at which its alarm input is high. It stays set after the alarm falls, until a clearing read of its group.
- R4: A strobe at sticky address BASE+2g+1 returns the sticky bits of group g as they were before that edge. At that edge, it clears the bits whose alarm is low.
- R5: An alarm that is high in the cycle of a clearing read remains set in the sticky view after the read. This holds both when the alarm is continuous and when it first rises in the read cycle.
- R6: A clearing read affects only the group it addresses.
- R7: A strobe at any address outside BASE to BASE+2*GROUPS-1 returns zero and changes no state.
- R8: rd_data is zero in any cycle that follows a cycle without a strobe.
- R9: While reset is asserted, and right after it is asserted, all sticky bits, rd_data and any_flag are zero, whatever the alarm inputs are.
- R10: any_flag is high exactly when at least one sticky bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Register address of the access |
| alarm_in | input | GROUPS*W | Alarm levels, active high, group g in bits [W*g+W-1:W*g] |
| rd_data | output | W | Data of the access made in the previous cycle |
| any_flag | output | 1 | High while any sticky bit is set |

## Verification
The bench builds the block with GROUPS=3, W=8, ADDR_W=6 and BASE=0x20, so the map spans 0x20 to 0x25. These values let the bench strobe addresses just below and just above the window. They also let a clearing read of one group run while another group holds a set bit, and let all three groups carry distinct patterns at once. The bench drives the same-cycle case, a rising alarm meeting a clearing read, and a reset applied while an alarm is high.

// File: rtl/asr_pkg.sv
package asr_pkg;

    // Kind of access made in the previous cycle
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LIVE   = 2'd1,
        ST_STICKY = 2'd2,
        ST_VOID   = 2'd3
    } rd_state_e;

endpackage

// File: rtl/asr_addr_decode.sv
module asr_addr_decode #(
    parameter int                 GROUPS = 3,
    parameter int                 ADDR_W = 6,
    parameter logic [ADDR_W-1:0]  BASE   = ADDR_W'('h20)
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [GROUPS-1:0] live_hit,
    output logic [GROUPS-1:0] sticky_hit,
    output logic              miss
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] LIVE_A = BASE + ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] STK_A  = LIVE_A + ADDR_W'(1);
        assign live_hit[g]   = rd_en && (rd_addr == LIVE_A);
        assign sticky_hit[g] = rd_en && (rd_addr == STK_A);
    end

    assign miss = rd_en && !(|live_hit) && !(|sticky_hit);

endmodule

// File: rtl/asr_sticky_bank.sv
module asr_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] alarm,
    input  logic         clr,
    output logic [W-1:0] q
);

    // Clear first, then OR in the present level, so that an alarm active
    // in the read cycle survives the clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~{W{clr}}) | alarm;
        end
    end

endmodule

// File: rtl/asr_read_mux.sv
module asr_read_mux #(
    parameter int GROUPS = 3,
    parameter int W      = 8
) (
    input  logic [GROUPS*W-1:0] live_vec,
    input  logic [GROUPS*W-1:0] sticky_vec,
    input  logic [GROUPS-1:0]   live_hit,
    input  logic [GROUPS-1:0]   sticky_hit,
    output logic [W-1:0]        sel_data
);

    always_comb begin
        sel_data = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (live_hit[g])   sel_data = sel_data | live_vec[g*W +: W];
            if (sticky_hit[g]) sel_data = sel_data | sticky_vec[g*W +: W];
        end
    end

endmodule

// File: rtl/asr_alarm_regs.sv
module asr_alarm_regs
    import asr_pkg::*;
#(
    parameter int                 GROUPS = 3,
    parameter int                 W      = 8,
    parameter int                 ADDR_W = 6,
    parameter logic [ADDR_W-1:0]  BASE   = ADDR_W'('h20)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [GROUPS*W-1:0] alarm_in,
    output logic [W-1:0]        rd_data,
    output logic                any_flag
);

    localparam int TOTAL = GROUPS * W;

    logic [GROUPS-1:0] live_hit;
    logic [GROUPS-1:0] sticky_hit;
    logic              miss;
    logic [TOTAL-1:0]  sticky_q;
    logic [W-1:0]      sel_data;
    logic [W-1:0]      snap_q;
    rd_state_e         state_q;
    rd_state_e         state_d;

    asr_addr_decode #(
        .GROUPS (GROUPS),
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_dec (
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .live_hit   (live_hit),
        .sticky_hit (sticky_hit),
        .miss       (miss)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_bank
        asr_sticky_bank #(.W(W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .alarm (alarm_in[g*W +: W]),
            .clr   (sticky_hit[g]),
            .q     (sticky_q[g*W +: W])
        );
    end

    asr_read_mux #(
        .GROUPS (GROUPS),
        .W      (W)
    ) u_mux (
        .live_vec   (alarm_in),
        .sticky_vec (sticky_q),
        .live_hit   (live_hit),
        .sticky_hit (sticky_hit),
        .sel_data   (sel_data)
    );

    // Next access kind
    always_comb begin
        if (!rd_en)          state_d = ST_IDLE;
        else if (miss)       state_d = ST_VOID;
        else if (|sticky_hit) state_d = ST_STICKY;
        else                 state_d = ST_LIVE;
    end

    // State register, with the data snapshot taken before any clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) snap_q <= sel_data;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_LIVE, ST_STICKY: rd_data = snap_q;
            ST_IDLE, ST_VOID:   rd_data = '0;
            default:            rd_data = '0;
        endcase
    end

    assign any_flag = |sticky_q;

endmodule

// File: rtl/asr_alarm_regs_chk.sv
module asr_alarm_regs_chk #(
    parameter int                 GROUPS = 3,
    parameter int                 W      = 8,
    parameter int                 ADDR_W = 6,
    parameter logic [ADDR_W-1:0]  BASE   = ADDR_W'('h20)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [GROUPS*W-1:0] alarm_in,
    input logic [W-1:0]        rd_data,
    input logic                any_flag,
    input logic [GROUPS*W-1:0] sticky_q
);

    logic mapped;
    always_comb begin
        mapped = 1'b0;
        for (int g = 0; g < 2 * GROUPS; g++) begin
            if (rd_addr == BASE + ADDR_W'(g)) mapped = 1'b1;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] LIVE_A = BASE + ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] STK_A  = LIVE_A + ADDR_W'(1);

        // R1
        live_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == LIVE_A) |=> rd_data == $past(alarm_in[g*W +: W]));

        // R4
        sticky_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == STK_A) |=>
                (rd_data == $past(sticky_q[g*W +: W])) &&
                (sticky_q[g*W +: W] == $past(alarm_in[g*W +: W])));

        // R6
        no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_en && rd_addr == STK_A) |=>
                sticky_q[g*W +: W] == ($past(sticky_q[g*W +: W]) | $past(alarm_in[g*W +: W])));
    end

    for (genvar b = 0; b < GROUPS * W; b++) begin : g_bit
        // R3
        level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            alarm_in[b] |=> sticky_q[b]);
    end

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> rd_data == '0);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);

    // R10
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_flag) |-> $past(alarm_in != '0));

endmodule

bind asr_alarm_regs asr_alarm_regs_chk #(
    .GROUPS (GROUPS),
    .W      (W),
    .ADDR_W (ADDR_W),
    .BASE   (BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .alarm_in (alarm_in),
    .rd_data  (rd_data),
    .any_flag (any_flag),
    .sticky_q (sticky_q)
);

// File: tb/tb_asr_alarm_regs.sv
module tb_asr_alarm_regs;

    localparam int CLK_PERIOD = 10;
    localparam int GROUPS = 3;
    localparam int W      = 8;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] BASE = 6'h20;
    localparam int NROWS = 18;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rd_en = 1'b0;
    logic [ADDR_W-1:0]   rd_addr = '0;
    logic [GROUPS*W-1:0] alarm_in = '0;
    logic [W-1:0]        rd_data;
    logic                any_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asr_alarm_regs #(
        .GROUPS (GROUPS),
        .W      (W),
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .alarm_in (alarm_in),
        .rd_data  (rd_data),
        .any_flag (any_flag)
    );

    // Row: {rd_en, addr[6], alarm[24], exp_data[8], exp_flag, req[4]}
    localparam logic [43:0] TBL [NROWS] = '{
        {1'b0, 6'h00, 24'h000000, 8'h00, 1'b0, 4'd8},  // R8 idle
        {1'b0, 6'h00, 24'h000081, 8'h00, 1'b1, 4'd3},  // R3 set g0
        {1'b1, 6'h21, 24'h000000, 8'h81, 1'b0, 4'd4},  // R4 clear g0
        {1'b1, 6'h22, 24'h000F00, 8'h0F, 1'b1, 4'd1},  // R1 live g1
        {1'b1, 6'h22, 24'h000000, 8'h00, 1'b1, 4'd2},  // R2 live no clear
        {1'b1, 6'h23, 24'h000000, 8'h0F, 1'b0, 4'd4},  // R4 held then cleared
        {1'b0, 6'h00, 24'h3C0000, 8'h00, 1'b1, 4'd3},  // R3 set g2
        {1'b1, 6'h25, 24'h3C0000, 8'h3C, 1'b1, 4'd5},  // R5 relatch
        {1'b1, 6'h25, 24'h000000, 8'h3C, 1'b0, 4'd5},  // R5 relatched value
        {1'b1, 6'h21, 24'h000010, 8'h00, 1'b1, 4'd5},  // R5 rise in read cycle
        {1'b1, 6'h23, 24'h000000, 8'h00, 1'b1, 4'd6},  // R6 other group kept
        {1'b1, 6'h30, 24'h000000, 8'h00, 1'b1, 4'd7},  // R7 above window
        {1'b1, 6'h1F, 24'h000000, 8'h00, 1'b1, 4'd7},  // R7 below window
        {1'b1, 6'h20, 24'h000000, 8'h00, 1'b1, 4'd2},  // R2 live g0
        {1'b1, 6'h21, 24'h000000, 8'h10, 1'b0, 4'd4},  // R4 g0 event kept
        {1'b0, 6'h22, 24'h00FF00, 8'h00, 1'b1, 4'd8},  // R8 addr without strobe
        {1'b1, 6'h24, 24'h000000, 8'h00, 1'b1, 4'd1},  // R1 live g2 zero
        {1'b1, 6'h23, 24'h000000, 8'hFF, 1'b0, 4'd10}  // R10 flag drops
    };

    task automatic chk(input string req, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic access(input logic en, input logic [ADDR_W-1:0] a,
                          input logic [GROUPS*W-1:0] al);
        rd_en    = en;
        rd_addr  = a;
        alarm_in = al;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 data", rd_data, 8'h00);
        chk("R9 flag", {7'd0, any_flag}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            logic [43:0] row;
            row = TBL[i];
            access(row[43], row[42:37], row[36:13]);
            chk($sformatf("R%0d row %0d data", row[3:0], i), rd_data, row[12:5]);
            chk($sformatf("R%0d row %0d flag", row[3:0], i), {7'd0, any_flag}, {7'd0, row[4]});
        end

        // R1 all groups distinct at once
        access(1'b1, 6'h20, 24'hA5C37E);
        chk("R1 g0 pattern", rd_data, 8'h7E);
        access(1'b1, 6'h24, 24'hA5C37E);
        chk("R1 g2 pattern", rd_data, 8'hA5);
        access(1'b1, 6'h22, 24'h000000);
        chk("R1 live follows input", rd_data, 8'h00);
        // R3 kept after alarm fell
        access(1'b1, 6'h23, 24'h000000);
        chk("R3 held g1", rd_data, 8'hC3);
        chk("R10 flag with g0 g2 set", {7'd0, any_flag}, 8'h01);

        // R9 reset while alarm is high
        alarm_in = 24'h010000;
        rst_n    = 1'b0;
        rd_en    = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 flag in reset", {7'd0, any_flag}, 8'h00);
        chk("R9 data in reset", rd_data, 8'h00);
        alarm_in = '0;
        rst_n    = 1'b1;
        access(1'b1, 6'h25, 24'h000000);
        chk("R9 sticky cleared by reset", rd_data, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule